// File: doc/BRIEF.md
# UART In-Band Software Flow Control Engine

This block sits beside one UART channel and adds character-based pause/resume signalling in both directions. On the receive side it inspects each byte before the byte reaches the receive FIFO. It recognises programmable stop and go characters, or two-byte stop and go sequences, and it removes those characters from the data stream. It holds a pause flag that stops the local transmitter. An optional mode lets any received byte release a pause.

On the transmit side it watches the receive FIFO fill level. When the level climbs to a halt threshold, it asks the transmitter to send the stop pattern to the far end. When the level falls back to a resume threshold, it asks for the go pattern. These injected characters go out ahead of ordinary FIFO data. Permission for the transmitter to start ordinary data is given only between characters, so a character already being shifted out always completes.

Serial framing, the FIFOs themselves and the register file are outside the block. Configuration arrives as plain inputs.

Top module: `swfc_ctrl`

## Requirements
- R1: Received bytes are offered at most once every two cycles. The result of a byte (written to the FIFO or dropped) appears on `rx_wr_valid`/`rx_wr_data` one cycle after the byte is sampled. After reset, `rx_wr_valid`, `tx_paused` and `inj_req` are 0.
- R2: With `cfg_en` low, every byte is passed unchanged, `tx_paused` reads 0 one cycle later, no character is injected, and `tx_go` equals `tx_idle`.
- R3: Single mode (`cfg_double`=0): a byte equal to `cfg_xoff1` is dropped and sets `tx_paused`. A byte equal to `cfg_xon1` is dropped and clears it. The stop character wins if both registers hold the same value.
- R4: A byte that matches no control pattern is written unchanged.
- R5: Double mode: `cfg_xoff1` followed by `cfg_xoff2` drops both and sets `tx_paused`. `cfg_xon1` followed by `cfg_xon2` drops both and clears it.
- R6: Double mode: if a first pattern byte is followed by any byte other than its partner, the held first byte is written in the cycle after the second byte arrives. The second byte is then evaluated one cycle later, as if it had just arrived.
- R7: Any-resume mode (`cfg_any`=1): while paused, a received byte clears `tx_paused`. A `cfg_xon1` byte doing so is dropped, and any other non-pattern byte is written. A stop pattern still pauses.
- R8: Any-resume in double mode while paused: `cfg_xon1` resumes at once without waiting for a partner. A following `cfg_xon2` is written as data.
- R9: When the far end is not halted and `rx_level` >= `cfg_halt_lvl`, the block requests the stop pattern. When the far end is halted and `rx_level` <= `cfg_resume_lvl`, it requests the go pattern. In double mode the two characters of a pattern are presented on `inj_char` first byte first. The far end counts as halted once the last stop character is acknowledged.
- R10: `inj_req` stays high, with the same `inj_char`, until `inj_ack`. `inj_ack` is only given while `inj_req` and `tx_idle` are high.
- R11: `tx_go` is high only when `tx_idle` is high, no injection is pending, and the channel is not paused (or flow control is off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Software flow control enable |
| cfg_double | input | 1 | 1 = two-byte patterns, 0 = single byte |
| cfg_any | input | 1 | Any received byte releases a pause |
| cfg_xon1 | input | 8 | First go character |
| cfg_xon2 | input | 8 | Second go character |
| cfg_xoff1 | input | 8 | First stop character |
| cfg_xoff2 | input | 8 | Second stop character |
| cfg_halt_lvl | input | 7 | FIFO level that triggers a stop request |
| cfg_resume_lvl | input | 7 | FIFO level that triggers a go request |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_level | input | 7 | Current receive FIFO fill level |
| tx_idle | input | 1 | Transmitter is between characters |
| inj_ack | input | 1 | Transmitter took the injected character |
| rx_wr_valid | output | 1 | Write strobe toward the receive FIFO |
| rx_wr_data | output | 8 | Byte to write |
| tx_paused | output | 1 | Far end asked this side to stop |
| tx_go | output | 1 | Transmitter may start the next FIFO character |
| inj_req | output | 1 | A control character must be sent next |
| inj_char | output | 8 | The control character to send |

## Verification
The assertions check several properties on every cycle. They cover the byte spacing on the input and the one-cycle timing of single-mode stop and of plain data. They also cover the release of pause when the feature is off, the hold of an injection request until acknowledged, the acknowledge only at a character boundary, and the ordering of a two-byte stop pattern. Other behaviours need sequences and are shown only by the bench's scenarios: the replay of an unmatched first byte, the any-resume corner where the second go byte becomes data, threshold hysteresis across a long level sweep, and priority of injection over FIFO data. For those, the bench's reference model is compared against every output on every cycle.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  typedef enum logic {
    K_XON  = 1'b0,
    K_XOFF = 1'b1
  } fc_kind_e;
endpackage

// File: rtl/swfc_rx_filter.sv
module swfc_rx_filter
  import swfc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dbl,
  input  logic          any_on,
  input  logic [CW-1:0] on1,
  input  logic [CW-1:0] on2,
  input  logic [CW-1:0] off1,
  input  logic [CW-1:0] off2,
  input  logic          in_v,
  input  logic [CW-1:0] in_c,
  output logic          paused,
  output logic          wr_v,
  output logic [CW-1:0] wr_c
);
  logic          pend_q, pend_d, rep_q, rep_d, paused_q, paused_d, wr_v_q, wr_v_d;
  fc_kind_e      pend_k_q, pend_k_d;
  logic [CW-1:0] pend_c_q, pend_c_d, rep_c_q, rep_c_d, wr_c_q, wr_c_d;
  logic          ev_v;
  logic [CW-1:0] ev_c;

  // Event: a replayed byte has priority; inputs never collide with it (R1).
  always_comb begin
    ev_v     = rep_q | in_v;
    ev_c     = rep_q ? rep_c_q : in_c;
    pend_d   = pend_q;
    pend_k_d = pend_k_q;
    pend_c_d = pend_c_q;
    rep_d    = 1'b0;
    rep_c_d  = rep_c_q;
    paused_d = paused_q;
    wr_v_d   = 1'b0;
    wr_c_d   = wr_c_q;
    if (!en) begin
      paused_d = 1'b0;
      if (pend_q) begin
        pend_d  = 1'b0;
        wr_v_d  = 1'b1;
        wr_c_d  = pend_c_q;
        rep_d   = ev_v;
        rep_c_d = ev_c;
      end else if (ev_v) begin
        wr_v_d = 1'b1;
        wr_c_d = ev_c;
      end
    end else if (ev_v) begin
      if (pend_q) begin
        pend_d = 1'b0;
        if (pend_k_q == K_XOFF && ev_c == off2) begin
          paused_d = 1'b1;
        end else if (pend_k_q == K_XON && ev_c == on2) begin
          paused_d = 1'b0;
        end else begin
          wr_v_d  = 1'b1;
          wr_c_d  = pend_c_q;
          rep_d   = 1'b1;
          rep_c_d = ev_c;
        end
      end else begin
        if (any_on) paused_d = 1'b0;
        if (ev_c == off1) begin
          if (dbl) begin
            pend_d   = 1'b1;
            pend_k_d = K_XOFF;
            pend_c_d = ev_c;
          end else begin
            paused_d = 1'b1;
          end
        end else if (ev_c == on1) begin
          if (dbl && !(any_on && paused_q)) begin
            pend_d   = 1'b1;
            pend_k_d = K_XON;
            pend_c_d = ev_c;
          end else begin
            paused_d = 1'b0;
          end
        end else begin
          wr_v_d = 1'b1;
          wr_c_d = ev_c;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pend_k_q <= K_XON;
      pend_c_q <= '0;
      rep_q    <= 1'b0;
      rep_c_q  <= '0;
      paused_q <= 1'b0;
      wr_v_q   <= 1'b0;
      wr_c_q   <= '0;
    end else begin
      pend_q   <= pend_d;
      pend_k_q <= pend_k_d;
      pend_c_q <= pend_c_d;
      rep_q    <= rep_d;
      rep_c_q  <= rep_c_d;
      paused_q <= paused_d;
      wr_v_q   <= wr_v_d;
      wr_c_q   <= wr_c_d;
    end
  end

  assign paused = paused_q;
  assign wr_v   = wr_v_q;
  assign wr_c   = wr_c_q;

  a_r1_byte_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    in_v |=> !in_v);
  a_r2_off_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !paused);
  a_r3_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dbl && in_v && !rep_q && !pend_q && in_c == off1) |=> (!wr_v && paused));
  a_r4_plain_data: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_v && !rep_q && !pend_q && in_c != off1 && in_c != on1)
      |=> (wr_v && wr_c == $past(in_c)));
endmodule

// File: rtl/swfc_tx_inject.sv
module swfc_tx_inject
  import swfc_pkg::*;
#(
  parameter int CW = 8,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dbl,
  input  logic [CW-1:0] on1,
  input  logic [CW-1:0] on2,
  input  logic [CW-1:0] off1,
  input  logic [CW-1:0] off2,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] halt_lvl,
  input  logic [LW-1:0] resume_lvl,
  input  logic          tx_idle,
  input  logic          ack,
  output logic          req,
  output logic [CW-1:0] chr
);
  logic     busy_q, busy_d, idx_q, idx_d, rhalt_q, rhalt_d;
  fc_kind_e kind_q, kind_d;

  always_comb begin
    busy_d  = busy_q;
    kind_d  = kind_q;
    idx_d   = idx_q;
    rhalt_d = rhalt_q;
    if (!en) begin
      busy_d  = 1'b0;
      idx_d   = 1'b0;
      rhalt_d = 1'b0;
    end else if (busy_q) begin
      if (ack) begin
        if (dbl && !idx_q) begin
          idx_d = 1'b1;
        end else begin
          busy_d  = 1'b0;
          idx_d   = 1'b0;
          rhalt_d = (kind_q == K_XOFF);
        end
      end
    end else if (!rhalt_q && level >= halt_lvl) begin
      busy_d = 1'b1;
      kind_d = K_XOFF;
    end else if (rhalt_q && level <= resume_lvl) begin
      busy_d = 1'b1;
      kind_d = K_XON;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      kind_q  <= K_XON;
      idx_q   <= 1'b0;
      rhalt_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      kind_q  <= kind_d;
      idx_q   <= idx_d;
      rhalt_q <= rhalt_d;
    end
  end

  assign req = busy_q;
  assign chr = (kind_q == K_XOFF) ? (idx_q ? off2 : off1) : (idx_q ? on2 : on1);

  a_r10_ack_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (req && tx_idle));
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (en && req && !ack) |=> (!en || req));
  a_r9_stop_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dbl && req && kind_q == K_XOFF && !idx_q && ack) |=> (!en || (req && chr == off2)));
endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl #(
  parameter int FIFO_DEPTH = 64,
  parameter int CW         = 8,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_double,
  input  logic          cfg_any,
  input  logic [CW-1:0] cfg_xon1,
  input  logic [CW-1:0] cfg_xon2,
  input  logic [CW-1:0] cfg_xoff1,
  input  logic [CW-1:0] cfg_xoff2,
  input  logic [LW-1:0] cfg_halt_lvl,
  input  logic [LW-1:0] cfg_resume_lvl,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  input  logic [LW-1:0] rx_level,
  input  logic          tx_idle,
  input  logic          inj_ack,
  output logic          rx_wr_valid,
  output logic [CW-1:0] rx_wr_data,
  output logic          tx_paused,
  output logic          tx_go,
  output logic          inj_req,
  output logic [CW-1:0] inj_char
);
  swfc_rx_filter #(.CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .dbl(cfg_double), .any_on(cfg_any),
    .on1(cfg_xon1), .on2(cfg_xon2), .off1(cfg_xoff1), .off2(cfg_xoff2),
    .in_v(rx_valid), .in_c(rx_data),
    .paused(tx_paused), .wr_v(rx_wr_valid), .wr_c(rx_wr_data)
  );

  swfc_tx_inject #(.CW(CW), .LW(LW)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .dbl(cfg_double),
    .on1(cfg_xon1), .on2(cfg_xon2), .off1(cfg_xoff1), .off2(cfg_xoff2),
    .level(rx_level), .halt_lvl(cfg_halt_lvl), .resume_lvl(cfg_resume_lvl),
    .tx_idle(tx_idle), .ack(inj_ack), .req(inj_req), .chr(inj_char)
  );

  // Ordinary data starts only at a boundary, behind injections (R11).
  assign tx_go = tx_idle & ~inj_req & (~tx_paused | ~cfg_en);
endmodule

// File: tb/swfc_ctrl_test.sv
module swfc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0, cfg_double = 1'b0, cfg_any = 1'b0;
  logic [7:0] cfg_xon1 = 8'h11, cfg_xon2 = 8'h12, cfg_xoff1 = 8'h13, cfg_xoff2 = 8'h14;
  logic [6:0] cfg_halt_lvl = 7'd60, cfg_resume_lvl = 7'd10;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [6:0] rx_level = 7'd20;
  logic       tx_idle = 1'b1, inj_ack = 1'b0;
  logic       rx_wr_valid, tx_paused, tx_go, inj_req;
  logic [7:0] rx_wr_data, inj_char;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit busy_pat = 1'b0, ack_en = 1'b1;
  logic [1:0] idle_ph = 2'd0;

  swfc_ctrl uut (.*);

  always #5 clk = ~clk;

  // Behavioural reference model
  bit       m_paused = 0, m_wr_v = 0, m_inj = 0, m_inj_off = 0, m_rhalt = 0;
  bit [7:0] m_wr_d = 0;
  int       m_sent = 0;
  bit [7:0] pend_fifo[$];
  bit [7:0] replay_fifo[$];

  always @(posedge clk or negedge rst_n) begin
    bit [7:0] ev, p;
    bit have;
    if (!rst_n) begin
      m_paused = 0; m_wr_v = 0; m_inj = 0; m_sent = 0; m_rhalt = 0;
      pend_fifo.delete(); replay_fifo.delete();
    end else begin
      have = 0;
      if (replay_fifo.size() > 0) begin ev = replay_fifo.pop_front(); have = 1; end
      else if (rx_valid) begin ev = rx_data; have = 1; end
      m_wr_v = 0;
      if (!cfg_en) begin
        m_paused = 0;
        if (pend_fifo.size() > 0) begin
          m_wr_v = 1; m_wr_d = pend_fifo.pop_front();
          if (have) replay_fifo.push_back(ev);
        end else if (have) begin m_wr_v = 1; m_wr_d = ev; end
      end else if (have) begin
        if (pend_fifo.size() > 0) begin
          p = pend_fifo.pop_front();
          if (p == cfg_xoff1 && ev == cfg_xoff2) m_paused = 1;
          else if (p == cfg_xon1 && ev == cfg_xon2) m_paused = 0;
          else begin m_wr_v = 1; m_wr_d = p; replay_fifo.push_back(ev); end
        end else begin
          bit was_paused;
          was_paused = m_paused;
          if (cfg_any) m_paused = 0;
          if (ev == cfg_xoff1) begin
            if (cfg_double) pend_fifo.push_back(ev); else m_paused = 1;
          end else if (ev == cfg_xon1) begin
            if (cfg_double && !(cfg_any && was_paused)) pend_fifo.push_back(ev);
            else m_paused = 0;
          end else begin
            m_wr_v = 1; m_wr_d = ev;
          end
        end
      end
      if (!cfg_en) begin
        m_inj = 0; m_sent = 0; m_rhalt = 0;
      end else if (m_inj) begin
        if (inj_ack) begin
          m_sent++;
          if (m_sent == (cfg_double ? 2 : 1)) begin
            m_inj = 0; m_sent = 0; m_rhalt = m_inj_off;
          end
        end
      end else if (!m_rhalt && rx_level >= cfg_halt_lvl) begin
        m_inj = 1; m_inj_off = 1;
      end else if (m_rhalt && rx_level <= cfg_resume_lvl) begin
        m_inj = 1; m_inj_off = 0;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, late in the low phase
  always @(negedge clk) begin
    bit [7:0] exp_c;
    bit exp_go;
    #4;
    if (rst_n) begin
      chk("rx_wr_valid", rx_wr_valid, m_wr_v);
      if (m_wr_v) chk("rx_wr_data", rx_wr_data, m_wr_d);
      chk("tx_paused", tx_paused, m_paused);
      chk("inj_req", inj_req, m_inj);
      if (m_inj) begin
        exp_c = m_inj_off ? (m_sent > 0 ? cfg_xoff2 : cfg_xoff1)
                          : (m_sent > 0 ? cfg_xon2 : cfg_xon1);
        chk("inj_char", inj_char, exp_c);
      end
      exp_go = tx_idle && !m_inj && (!m_paused || !cfg_en);
      chk("tx_go (R11)", tx_go, exp_go);
    end
  end

  // Transmitter stand-in: boundary pattern and acknowledge
  always @(negedge clk) begin
    idle_ph = idle_ph + 2'd1;
    tx_idle = busy_pat ? (idle_ph == 2'd0) : 1'b1;
    inj_ack = ack_en && inj_req && tx_idle;
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("reset rx_wr_valid", rx_wr_valid, 0);
    chk("reset tx_paused", tx_paused, 0);
    chk("reset inj_req", inj_req, 0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R2";
    send(8'h41); send(8'h13); send(8'h11); send(8'h7e);
    idle(3);

    cur_req = "R3";
    cfg_en = 1'b1;
    send(8'h41); send(8'h13); idle(4);
    cur_req = "R11";
    busy_pat = 1'b1; idle(8); busy_pat = 1'b0;
    cur_req = "R4";
    send(8'h42); send(8'h00); send(8'hff);
    cur_req = "R3";
    send(8'h11); idle(2);
    cur_req = "R2";
    send(8'h13); cfg_en = 1'b0; idle(3); cfg_en = 1'b1;

    cur_req = "R5";
    cfg_double = 1'b1;
    send(8'h13); send(8'h14); idle(2);
    send(8'h11); send(8'h12); idle(2);
    cur_req = "R6";
    send(8'h13); send(8'h5a); idle(2);
    send(8'h11); send(8'h13); send(8'h14); idle(2);
    send(8'h11); send(8'h12);
    send(8'h11); cfg_en = 1'b0; idle(3); cfg_en = 1'b1;

    cur_req = "R7";
    cfg_double = 1'b0; cfg_any = 1'b1;
    send(8'h13); send(8'h51); idle(2);
    send(8'h13); send(8'h11); idle(2);
    send(8'h13); send(8'h13); send(8'h12); idle(2);

    cur_req = "R8";
    cfg_double = 1'b1;
    send(8'h13); send(8'h14); send(8'h11); send(8'h12); idle(2);
    send(8'h11); send(8'h12);
    cfg_any = 1'b0;

    cur_req = "R9";
    rx_level = 7'd60; idle(6);
    rx_level = 7'd30; idle(6);
    rx_level = 7'd10; idle(6);
    cur_req = "R10";
    busy_pat = 1'b1; rx_level = 7'd63; idle(12);
    ack_en = 1'b0; rx_level = 7'd5; idle(10);
    ack_en = 1'b1; idle(12);
    cur_req = "R9";
    cfg_double = 1'b0; busy_pat = 1'b0;
    rx_level = 7'd60; idle(5); rx_level = 7'd11; idle(4); rx_level = 7'd10; idle(5);
    cur_req = "R11";
    rx_level = 7'd61; send(8'h13); idle(6);
    cur_req = "R2";
    cfg_en = 1'b0; idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule